// File: doc/BRIEF.md
# Multi-Mode 24-Bit Timer/Counter

This block is a 24-bit up-counter with three ways of using it, picked by a two-bit mode input. In interval mode it counts up to a compare value and then either restarts from zero or parks there. In pulse mode two compare values toggle a flip-flop output, which gives a programmable waveform, and the second compare value also restarts the count. In watchdog mode the counter raises a timeout at the compare value and restarts. The block holds no registers of its own for these settings. A register bank elsewhere drives every control field as a plain input, and it also provides the reset values of the compare fields.

A count step is either a tick from a free-running power-of-two prescaler on the system clock, or a rising edge of an external count clock that has been brought into the system clock domain. At most one step happens per system clock. Each event produces a one-cycle status strobe. It also produces a one-cycle interrupt pulse when that event's interrupt enable is set. Both appear in the same cycle as the counter update they belong to.

Top module: `tmr24_core`

## Requirements
- R1: While `rst` is high, on each clock edge `count` goes to 0, `ff_out` is loaded from `ff_init`, and `irq` and every status strobe stay low.
- R2: The encoding of `mode` is 0 = interval, 1 = pulse, 2 = watchdog and 3 = off. In mode 3 `count` never changes, whatever `run_en` is.
- R3: With `src_ext` = 0 and `div_en` = 0, the counter can step on every clock. With `div_en` = 1 it steps once every 2^(`div_sel`+1) clocks. The first such step comes 2^(`div_sel`+1) clocks after reset is released.
- R4: With `src_ext` = 1, the counter steps once for each rising edge of `ext_clk`, a few clocks after that edge, and `div_en`/`div_sel` have no effect.
- R5: In interval mode, the step whose next value equals `cmp_a` pulses `stat_iv`. Then `count` becomes 0 if `zero_clr` = 1. Otherwise `count` stays at `cmp_a` and does not advance again.
- R6: In interval mode, `irq` pulses only on the step that arrives at `cmp_a` and only if `ie_iv` = 1. It does not pulse again while the counter is held at `cmp_a`.
- R7: In pulse mode, the step whose next value equals `cmp_a` toggles `ff_out`, pulses `stat_a`, and pulses `irq` if `ie_a` = 1.
- R8: In pulse mode, the step whose next value equals `cmp_b` (and not `cmp_a`) toggles `ff_out`, pulses `stat_b`, pulses `irq` if `ie_b` = 1, and sets `count` to 0.
- R9: In watchdog mode, the step whose next value equals `cmp_a` pulses `stat_wd`, pulses `irq` if `ie_wd` = 1, and sets `count` to 0.
- R10: In interval and pulse modes, `run_en` = 0 stops the counter. In watchdog mode the counter stops only when `run_en` = 0 and `wd_dis` = 1.
- R11: At most one status strobe is high in any cycle, and `irq` is high only in a cycle where a status strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk | input | 1 | External count clock, asynchronous |
| mode | input | 2 | Operating mode (0 interval, 1 pulse, 2 watchdog, 3 off) |
| run_en | input | 1 | Timer enable |
| src_ext | input | 1 | Count source: 0 internal prescaler, 1 external clock |
| div_en | input | 1 | Enable internal prescaler division |
| div_sel | input | 3 | Prescaler exponent n, division 2^(n+1) |
| zero_clr | input | 1 | Interval mode: restart at compare A instead of holding |
| wd_dis | input | 1 | Watchdog may be stopped when run_en is 0 |
| ff_init | input | 1 | Flip-flop value loaded on reset |
| ie_iv | input | 1 | Interval interrupt enable |
| ie_a | input | 1 | Pulse compare A interrupt enable |
| ie_b | input | 1 | Pulse compare B interrupt enable |
| ie_wd | input | 1 | Watchdog interrupt enable |
| cmp_a | input | 24 | Compare value A |
| cmp_b | input | 24 | Compare value B |
| count | output | 24 | Counter value |
| stat_iv | output | 1 | Interval match strobe |
| stat_a | output | 1 | Pulse compare A strobe |
| stat_b | output | 1 | Pulse compare B strobe |
| stat_wd | output | 1 | Watchdog expiry strobe |
| irq | output | 1 | Interrupt pulse |
| ff_out | output | 1 | Pulse generator flip-flop |

## Verification
The counter value is on a port, so a wrong step, hold or clear decision shows on `count` in the very next cycle. Errors in the prescaler phase or the synchronizer edge detect show up as a miscount after a known number of clocks. A wrong flip-flop toggle stays visible on `ff_out` until the next compare event, which makes the final `ff_out` value a record of how many toggles happened. Errors in interrupt gating appear as a wrong number of `irq` pulses over a run. That includes a pulse that repeats while the interval counter is held.

// File: rtl/tmr24_core.sv
module tmr24_core #(
  parameter int W  = 24,
  parameter int DW = 3,
  parameter int PW = 1 << DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_clk,
  input  logic [1:0]    mode,
  input  logic          run_en,
  input  logic          src_ext,
  input  logic          div_en,
  input  logic [DW-1:0] div_sel,
  input  logic          zero_clr,
  input  logic          wd_dis,
  input  logic          ff_init,
  input  logic          ie_iv,
  input  logic          ie_a,
  input  logic          ie_b,
  input  logic          ie_wd,
  input  logic [W-1:0]  cmp_a,
  input  logic [W-1:0]  cmp_b,
  output logic [W-1:0]  count,
  output logic          stat_iv,
  output logic          stat_a,
  output logic          stat_b,
  output logic          stat_wd,
  output logic          irq,
  output logic          ff_out
);

  localparam logic [1:0] M_IV  = 2'd0;
  localparam logic [1:0] M_PG  = 2'd1;
  localparam logic [1:0] M_WD  = 2'd2;

  logic [PW-1:0] pre;
  logic [PW-1:0] pmask;
  logic [2:0]    xs;
  logic          int_tick, ext_tick, tick, go, step;
  logic [W-1:0]  nxt;

  assign pmask    = PW'((32'd2 << div_sel) - 32'd1);
  assign int_tick = !div_en || ((pre & pmask) == pmask);
  assign ext_tick = xs[1] & ~xs[2];
  assign tick     = src_ext ? ext_tick : int_tick;
  assign nxt      = count + W'(1);
  assign step     = tick & go;

  always_comb begin
    case (mode)
      M_IV:    go = run_en && (count != cmp_a);
      M_PG:    go = run_en;
      M_WD:    go = run_en || !wd_dis;
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      xs  <= '0;
    end else begin
      pre <= pre + PW'(1);
      xs  <= {xs[1:0], ext_clk};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      ff_out  <= ff_init;
      stat_iv <= 1'b0;
      stat_a  <= 1'b0;
      stat_b  <= 1'b0;
      stat_wd <= 1'b0;
      irq     <= 1'b0;
    end else begin
      stat_iv <= 1'b0;
      stat_a  <= 1'b0;
      stat_b  <= 1'b0;
      stat_wd <= 1'b0;
      irq     <= 1'b0;
      if (step) begin
        count <= nxt;
        case (mode)
          M_IV: if (nxt == cmp_a) begin
            stat_iv <= 1'b1;
            irq     <= ie_iv;
            count   <= zero_clr ? '0 : cmp_a;
          end
          M_PG: if (nxt == cmp_a) begin
            ff_out <= ~ff_out;
            stat_a <= 1'b1;
            irq    <= ie_a;
          end else if (nxt == cmp_b) begin
            ff_out <= ~ff_out;
            stat_b <= 1'b1;
            irq    <= ie_b;
            count  <= '0;
          end
          M_WD: if (nxt == cmp_a) begin
            stat_wd <= 1'b1;
            irq     <= ie_wd;
            count   <= '0;
          end
          default: count <= count;
        endcase
      end
    end
  end

endmodule

// File: rtl/tmr24_props.sv
module tmr24_props #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         run_en,
  input logic         wd_dis,
  input logic         ff_init,
  input logic [W-1:0] count,
  input logic         stat_iv,
  input logic         stat_a,
  input logic         stat_b,
  input logic         stat_wd,
  input logic         irq,
  input logic         ff_out
);

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0 && !irq && !stat_iv && !stat_a && !stat_b && !stat_wd));

  a_r2_off_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> $stable(count));

  a_r10_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_en && (mode != 2'd2 || wd_dis)) |=> $stable(count));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat_iv, stat_a, stat_b, stat_wd}));

  a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_iv || stat_a || stat_b || stat_wd));

  a_r7_ff_toggles_on_compare: assert property (@(posedge clk) disable iff (rst)
    (stat_a || stat_b) |-> (ff_out != $past(ff_out)));

  a_r8_ff_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    (!stat_a && !stat_b && !$past(rst)) |-> $stable(ff_out));

  a_r9_wd_clears: assert property (@(posedge clk) disable iff (rst)
    stat_wd |-> (count == '0));

  a_r8_b_clears: assert property (@(posedge clk) disable iff (rst)
    stat_b |-> (count == '0));

endmodule

bind tmr24_core tmr24_props #(.W(W)) u_props (.*);

// File: tb/test_tmr24_core.sv
`timescale 1ns/1ps
module test_tmr24_core;

  typedef struct packed {
    logic [1:0]  md;
    logic        run;
    logic        wdd;
    logic        zc;
    logic        den;
    logic [2:0]  dsel;
    logic        ffi;
    logic [23:0] ca;
    logic [23:0] cb;
    logic [15:0] n;
    logic [23:0] ecnt;
    logic        eff;
    logic [7:0]  eirq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 24'd10,  24'd0, 16'd25, 24'd5,  1'b0, 8'd2}, // R5 R6 clear
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 24'd10,  24'd0, 16'd25, 24'd10, 1'b0, 8'd1}, // R5 R6 hold
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 24'd3,   24'd8, 16'd20, 24'd4,  1'b1, 8'd5}, // R7 R8
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 24'd6,   24'd0, 16'd15, 24'd3,  1'b0, 8'd2}, // R9
    '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 24'd100, 24'd0, 16'd30, 24'd7,  1'b0, 8'd0}, // R3 /4
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 24'd10,  24'd0, 16'd20, 24'd0,  1'b0, 8'd0}, // R2
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 24'd10,  24'd0, 16'd20, 24'd0,  1'b0, 8'd0}, // R10
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 24'd100, 24'd0, 16'd9,  24'd9,  1'b0, 8'd0}, // R10 wd runs
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 24'd100, 24'd0, 16'd9,  24'd0,  1'b0, 8'd0}, // R10 wd stops
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 24'd2,   24'd5, 16'd5,  24'd0,  1'b1, 8'd2}, // R1 R7 R8
    '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 24'd100, 24'd0, 16'd9,  24'd4,  1'b0, 8'd0}  // R3 /2
  };

  logic clk = 1'b0, rst = 1'b1, ext_clk = 1'b0;
  logic [1:0] mode = 2'd0;
  logic run_en = 1'b0, src_ext = 1'b0, div_en = 1'b0, zero_clr = 1'b0, wd_dis = 1'b0, ff_init = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic ie_iv = 1'b1, ie_a = 1'b1, ie_b = 1'b1, ie_wd = 1'b1;
  logic [23:0] cmp_a = 24'd0, cmp_b = 24'd0;
  logic [23:0] count;
  logic stat_iv, stat_a, stat_b, stat_wd, irq, ff_out;

  int applied = 0, bad = 0, irqn = 0;

  always #4 clk = ~clk;

  tmr24_core i_tmr24_core (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .mode(mode), .run_en(run_en),
    .src_ext(src_ext), .div_en(div_en), .div_sel(div_sel), .zero_clr(zero_clr),
    .wd_dis(wd_dis), .ff_init(ff_init), .ie_iv(ie_iv), .ie_a(ie_a), .ie_b(ie_b),
    .ie_wd(ie_wd), .cmp_a(cmp_a), .cmp_b(cmp_b), .count(count), .stat_iv(stat_iv),
    .stat_a(stat_a), .stat_b(stat_b), .stat_wd(stat_wd), .irq(irq), .ff_out(ff_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input vec_t v);
    @(negedge clk);
    rst = 1'b1;
    mode = v.md; run_en = v.run; wd_dis = v.wdd; zero_clr = v.zc;
    div_en = v.den; div_sel = v.dsel; ff_init = v.ffi; cmp_a = v.ca; cmp_b = v.cb;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 count", 32'(count), 32'd0);
    chk("R1 ff_out", 32'(ff_out), 32'(v.ffi));
  endtask

  task automatic run(input vec_t v, input string req);
    start(v);
    irqn = 0;
    for (int k = 0; k < int'(v.n); k++) begin
      @(negedge clk);
      irqn += int'(irq);
    end
    chk({req, " count"}, 32'(count), 32'(v.ecnt));
    chk({req, " ff_out"}, 32'(ff_out), 32'(v.eff));
    chk({req, " irq pulses"}, 32'(irqn), 32'(v.eirq));
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d", i));

    // R7 R8: compare A interrupt masked, compare B enabled
    ie_a = 1'b0;
    run('{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 24'd3, 24'd8, 16'd20, 24'd4, 1'b1, 8'd2}, "R7 R8 mask");
    ie_a = 1'b1;

    // R6: interval interrupt masked
    ie_iv = 1'b0;
    run('{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 24'd4, 24'd0, 16'd10, 24'd2, 1'b0, 8'd0}, "R6 mask");
    ie_iv = 1'b1;

    // R4: external clock, prescaler settings ignored
    src_ext = 1'b1;
    start('{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd7, 1'b0, 24'd100, 24'd0, 16'd0, 24'd0, 1'b0, 8'd0});
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1'b1;
      repeat (5) @(negedge clk);
      ext_clk = 1'b0;
      repeat (5) @(negedge clk);
    end
    chk("R4 ext count", 32'(count), 32'd5);
    repeat (10) @(negedge clk);
    chk("R4 no drift", 32'(count), 32'd5);
    src_ext = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule